// File: doc/BRIEF.md
# Hardware Cursor Overlay with Edge Clipping

This block places a small cursor image over a live pixel stream. The image is held on chip in two equal banks of 32-bit ARGB words, loaded through a sequential write port. A separate transparency store keeps a 2-bit code for every image pixel and decides whether the image, the background or the inverted background is shown. A single write port loads the image. The transparency store has its own addressed write port.

Once per frame the block takes a signed cursor position, the cursor size, the display size and an interlace flag. From these it clips the cursor against all four screen edges. It reports the visible size, the on-screen start and the first image pixel shown, and then replaces background pixels inside the visible window. Each pixel arrives with its screen coordinates and leaves one clock later.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held and right after it, `pix_out_valid`, `pix_out`, `cur_on` and the three packed outputs are all zero.
- R2: A size is legal only when width and height are each between 1 and MAX_LONG and not both above MAX_SHORT; an illegal active size keeps `cur_on` low.
- R3: For a negative position on an axis, the image offset is minus the position, the screen start is 0 and the visible length is the size plus the position, floored at 0 and capped at the display length.
- R4: When position plus size exceeds the display length on an axis, the visible length is the display length minus the position, floored at 0; a visible width or height of 0 keeps `cur_on` low.
- R5: With interlace active, the clipped visible height and screen start row are halved (rounded down), and each field row steps two image rows.
- R6: `cur_pos`, `cur_size` and `cur_src` each carry the vertical value in the upper CW bits and the horizontal value in the lower CW bits.
- R7: `img_load_start` rewinds the write pointer; each `img_wr_en` stores the next pixel in row-major order with row stride equal to the width; red and blue bytes are swapped on storage; pixel indices from PIX_MAX/2 upward go to the second bank; the pixel bus carries blue in bits 23:16, green in 15:8 and red in 7:0.
- R8: The size present at `img_load_start` is remembered; if the active size differs from it, or no pixel has been written since that start, `cur_on` stays low.
- R9: Enable, position, size, display size and interlace take effect only at a cycle with `frame_start` high; the packed outputs change only in the cycle after such a cycle.
- R10: Image pixel p uses transparency word p/16, bits 2*(p%16)+1 down to 2*(p%16); code 00 shows the image colour, 01 the background, 10 the inverted background, 11 the image colour when its alpha byte is nonzero and the background otherwise.
- R11: After reset and after every fall of `ram_sleep`, every transparency word is filled with 0x55555555 over one word per cycle; port writes made during that sweep are dropped, and `cur_on` is low until it ends.
- R12: While `ram_sleep` is high `cur_on` is low, and the image counts as unloaded afterwards until a new load.
- R13: `pix_out_valid` follows `pix_valid` by one cycle; `pix_out` changes only after a valid pixel, and pixels outside the visible window, or with `cur_on` low, pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Cursor enable request |
| cfg_pos_x | input | CW | Signed horizontal position |
| cfg_pos_y | input | CW | Signed vertical position |
| cfg_size_w | input | SZW | Cursor width |
| cfg_size_h | input | SZW | Cursor height |
| cfg_disp_w | input | CW | Active display width |
| cfg_disp_h | input | CW | Active display height |
| cfg_interlace | input | 1 | Interlaced timing |
| frame_start | input | 1 | Frame boundary strobe, loads the settings |
| ram_sleep | input | 1 | Cursor memories powered down |
| img_load_start | input | 1 | Rewind image write pointer, latch load size |
| img_wr_en | input | 1 | Write one ARGB pixel |
| img_wr_data | input | 32 | ARGB pixel, alpha in 31:24, red in 23:16 |
| tr_wr_en | input | 1 | Transparency word write |
| tr_wr_addr | input | TRA_W | Transparency word address |
| tr_wr_data | input | 32 | Transparency word |
| pix_valid | input | 1 | Background pixel valid |
| pix_x | input | CW | Pixel column |
| pix_y | input | CW | Pixel row |
| pix_in | input | 24 | Background pixel |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 24 | Output pixel |
| cur_on | output | 1 | Cursor drawn this frame |
| cur_pos | output | 2*CW | Screen start {row, column} |
| cur_size | output | 2*CW | Visible {height, width} |
| cur_src | output | 2*CW | First image pixel shown {row, column} |

## Verification
The bench builds the block with MAX_LONG 8 and MAX_SHORT 4, so the image has 32 pixels split into two banks of 16 and the transparency store has two words. At that size every image index, the bank switch at 16, both transparency words and the full fill sweep can be reached with a few dozen writes. The 4-bit size fields also allow widths above MAX_LONG, so the illegal-size paths are exercised. A 20 by 12 display puts the left, right, top and bottom clipping cases, and complete clipping off-screen, within a handful of pixels.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  typedef enum logic [1:0] {
    TR_SOLID  = 2'b00,
    TR_CLEAR  = 2'b01,
    TR_INVERT = 2'b10,
    TR_KEYED  = 2'b11
  } tr_code_e;

  localparam logic [31:0] TR_FILL = 32'h5555_5555;

  // exchange red and blue bytes of an ARGB word
  function automatic logic [31:0] swap_rb(input logic [31:0] argb);
    return {argb[31:24], argb[7:0], argb[15:8], argb[23:16]};
  endfunction

endpackage

// File: rtl/cursor_axis_clip.sv
module cursor_axis_clip #(
  parameter int CW  = 16,
  parameter int SZW = 7
) (
  input  logic signed [CW-1:0]  pos,
  input  logic        [SZW-1:0] len,
  input  logic        [CW-1:0]  lim,
  output logic        [CW-1:0]  off,
  output logic        [CW-1:0]  scr,
  output logic        [CW-1:0]  vis
);
  localparam int EW = CW + 2;

  logic signed [EW-1:0] p_e, s_e, l_e, end_e, neg_e, rem_e;

  always_comb begin
    p_e   = {{2{pos[CW-1]}}, pos};
    s_e   = {{(EW-SZW){1'b0}}, len};
    l_e   = {2'b00, lim};
    end_e = p_e + s_e;
    neg_e = -p_e;
    rem_e = l_e - p_e;
    off   = '0;
    scr   = '0;
    vis   = '0;
    if (p_e < 0) begin
      off = neg_e[CW-1:0];
      if (end_e > l_e)      vis = lim;
      else if (end_e > 0)   vis = end_e[CW-1:0];
    end else if (end_e > l_e) begin
      scr = p_e[CW-1:0];
      if (rem_e > 0)        vis = rem_e[CW-1:0];
    end else begin
      scr = p_e[CW-1:0];
      vis = s_e[CW-1:0];
    end
  end

endmodule

// File: rtl/cursor_img_ram.sv
module cursor_img_ram
  import cursor_pkg::*;
#(
  parameter int PIX_MAX = 2048,
  localparam int IDX_W  = $clog2(PIX_MAX),
  localparam int BANK   = PIX_MAX / 2,
  localparam int BA_W   = IDX_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word
);
  logic [IDX_W-1:0] wr_ptr, wr_ptr_nxt;
  logic [31:0]      bank_rd [2];

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    if (load_start)  wr_ptr_nxt = '0;
    else if (wr_en)  wr_ptr_nxt = wr_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= wr_ptr_nxt;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [31:0] mem [BANK];
    logic        we;
    assign we = wr_en && !load_start && (wr_ptr[IDX_W-1] == 1'(b));
    always_ff @(posedge clk) begin
      if (we) mem[wr_ptr[BA_W-1:0]] <= swap_rb(wr_data);
    end
    assign bank_rd[b] = mem[rd_idx[BA_W-1:0]];
  end

  assign rd_word = bank_rd[rd_idx[IDX_W-1]];

endmodule

// File: rtl/cursor_tr_ram.sv
module cursor_tr_ram
  import cursor_pkg::*;
#(
  parameter int PIX_MAX  = 2048,
  localparam int IDX_W   = $clog2(PIX_MAX),
  localparam int TRA_W   = IDX_W - 4,
  localparam int TR_WORDS = PIX_MAX / 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             wr_en,
  input  logic [TRA_W-1:0] wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output tr_code_e         code,
  output logic             busy
);
  logic [31:0]      mem [TR_WORDS];
  logic [TRA_W-1:0] fill_ptr, fill_ptr_nxt;
  logic             busy_nxt;
  logic [31:0]      rd_word;

  always_comb begin
    busy_nxt     = busy;
    fill_ptr_nxt = fill_ptr;
    if (sleep) begin
      busy_nxt     = 1'b1;
      fill_ptr_nxt = '0;
    end else if (busy) begin
      if (fill_ptr == TRA_W'(TR_WORDS - 1)) busy_nxt = 1'b0;
      else                                  fill_ptr_nxt = fill_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b1;
      fill_ptr <= '0;
    end else begin
      busy     <= busy_nxt;
      fill_ptr <= fill_ptr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep && busy)         mem[fill_ptr] <= TR_FILL;
    else if (!sleep && wr_en)   mem[wr_addr]  <= wr_data;
  end

  assign rd_word = mem[rd_idx[IDX_W-1:4]];
  assign code    = tr_code_e'(rd_word[{rd_idx[3:0], 1'b0} +: 2]);

endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
  import cursor_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [23:0] bg,
  input  logic        hit,
  input  tr_code_e    code,
  input  logic [31:0] img,
  output logic        out_valid,
  output logic [23:0] out_pix
);
  logic [23:0] mix, out_nxt;

  always_comb begin
    mix = bg;
    if (hit) begin
      unique case (code)
        TR_SOLID:  mix = img[23:0];
        TR_CLEAR:  mix = bg;
        TR_INVERT: mix = ~bg;
        TR_KEYED:  mix = (img[31:24] != 8'h00) ? img[23:0] : bg;
        default:   mix = bg;
      endcase
    end
    out_nxt = in_valid ? mix : out_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      out_pix   <= out_nxt;
    end
  end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int CW        = 16,
  parameter int MAX_LONG  = 64,
  parameter int MAX_SHORT = 32,
  localparam int SZW      = $clog2(MAX_LONG) + 1,
  localparam int PIX_MAX  = MAX_LONG * MAX_SHORT,
  localparam int IDX_W    = $clog2(PIX_MAX),
  localparam int TRA_W    = IDX_W - 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_enable,
  input  logic signed [CW-1:0] cfg_pos_x,
  input  logic signed [CW-1:0] cfg_pos_y,
  input  logic [SZW-1:0]       cfg_size_w,
  input  logic [SZW-1:0]       cfg_size_h,
  input  logic [CW-1:0]        cfg_disp_w,
  input  logic [CW-1:0]        cfg_disp_h,
  input  logic                 cfg_interlace,
  input  logic                 frame_start,
  input  logic                 ram_sleep,
  input  logic                 img_load_start,
  input  logic                 img_wr_en,
  input  logic [31:0]          img_wr_data,
  input  logic                 tr_wr_en,
  input  logic [TRA_W-1:0]     tr_wr_addr,
  input  logic [31:0]          tr_wr_data,
  input  logic                 pix_valid,
  input  logic [CW-1:0]        pix_x,
  input  logic [CW-1:0]        pix_y,
  input  logic [23:0]          pix_in,
  output logic                 pix_out_valid,
  output logic [23:0]          pix_out,
  output logic                 cur_on,
  output logic [2*CW-1:0]      cur_pos,
  output logic [2*CW-1:0]      cur_size,
  output logic [2*CW-1:0]      cur_src
);
  // settings applied at the frame boundary
  logic                 act_en, act_il;
  logic signed [CW-1:0] act_x, act_y;
  logic [SZW-1:0]       act_w, act_h;
  logic [CW-1:0]        act_dw, act_dh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en <= 1'b0;
      act_il <= 1'b0;
      act_x  <= '0;
      act_y  <= '0;
      act_w  <= '0;
      act_h  <= '0;
      act_dw <= '0;
      act_dh <= '0;
    end else if (frame_start) begin
      act_en <= cfg_enable;
      act_il <= cfg_interlace;
      act_x  <= cfg_pos_x;
      act_y  <= cfg_pos_y;
      act_w  <= cfg_size_w;
      act_h  <= cfg_size_h;
      act_dw <= cfg_disp_w;
      act_dh <= cfg_disp_h;
    end
  end

  // image load bookkeeping: size at load start and a written flag
  logic [SZW-1:0] img_w, img_h, img_w_nxt, img_h_nxt;
  logic           loaded, loaded_nxt;

  always_comb begin
    img_w_nxt  = img_w;
    img_h_nxt  = img_h;
    loaded_nxt = loaded;
    if (ram_sleep) begin
      loaded_nxt = 1'b0;
    end else if (img_load_start) begin
      loaded_nxt = 1'b0;
      img_w_nxt  = cfg_size_w;
      img_h_nxt  = cfg_size_h;
    end else if (img_wr_en) begin
      loaded_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_w  <= '0;
      img_h  <= '0;
      loaded <= 1'b0;
    end else begin
      img_w  <= img_w_nxt;
      img_h  <= img_h_nxt;
      loaded <= loaded_nxt;
    end
  end

  // clipping per axis
  logic [CW-1:0] src_x, src_y, scr_x, scr_y, vis_w, vis_h;

  cursor_axis_clip #(.CW(CW), .SZW(SZW)) u_clip_x (
    .pos(act_x), .len(act_w), .lim(act_dw),
    .off(src_x), .scr(scr_x), .vis(vis_w)
  );

  cursor_axis_clip #(.CW(CW), .SZW(SZW)) u_clip_y (
    .pos(act_y), .len(act_h), .lim(act_dh),
    .off(src_y), .scr(scr_y), .vis(vis_h)
  );

  logic [CW-1:0] fld_h, fld_y;
  assign fld_h = act_il ? (vis_h >> 1) : vis_h;
  assign fld_y = act_il ? (scr_y >> 1) : scr_y;

  logic size_ok, tr_busy;
  assign size_ok = (act_w != '0) && (act_h != '0) &&
                   (act_w <= SZW'(MAX_LONG)) && (act_h <= SZW'(MAX_LONG)) &&
                   !((act_w > SZW'(MAX_SHORT)) && (act_h > SZW'(MAX_SHORT)));

  assign cur_on = act_en && size_ok && loaded && !ram_sleep && !tr_busy &&
                  (img_w == act_w) && (img_h == act_h) &&
                  (vis_w != '0) && (fld_h != '0);

  assign cur_pos  = {fld_y, scr_x};
  assign cur_size = {fld_h, vis_w};
  assign cur_src  = {src_y, src_x};

  // window test and image index for the incoming pixel
  logic          in_x, in_y, hit;
  logic [CW-1:0] col, row, src_col, src_row;
  logic [IDX_W-1:0] rd_idx;

  always_comb begin
    in_x    = (pix_x >= scr_x);
    in_y    = (pix_y >= fld_y);
    col     = pix_x - scr_x;
    row     = pix_y - fld_y;
    in_x    = in_x && (col < vis_w);
    in_y    = in_y && (row < fld_h);
    src_col = src_x + col;
    src_row = src_y + (act_il ? (row << 1) : row);
    rd_idx  = IDX_W'(src_row) * IDX_W'(act_w) + IDX_W'(src_col);
    hit     = cur_on && in_x && in_y;
  end

  logic [31:0] img_word;
  tr_code_e    tr_code;

  cursor_img_ram #(.PIX_MAX(PIX_MAX)) u_img (
    .clk(clk), .rst_n(rst_n),
    .load_start(img_load_start), .wr_en(img_wr_en), .wr_data(img_wr_data),
    .rd_idx(rd_idx), .rd_word(img_word)
  );

  cursor_tr_ram #(.PIX_MAX(PIX_MAX)) u_tr (
    .clk(clk), .rst_n(rst_n), .sleep(ram_sleep),
    .wr_en(tr_wr_en), .wr_addr(tr_wr_addr), .wr_data(tr_wr_data),
    .rd_idx(rd_idx), .code(tr_code), .busy(tr_busy)
  );

  cursor_blend u_blend (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pix_valid), .bg(pix_in), .hit(hit), .code(tr_code), .img(img_word),
    .out_valid(pix_out_valid), .out_pix(pix_out)
  );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int CW       = 16,
  parameter int MAX_LONG = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_start,
  input logic            ram_sleep,
  input logic            pix_valid,
  input logic [23:0]     pix_in,
  input logic            pix_out_valid,
  input logic [23:0]     pix_out,
  input logic            cur_on,
  input logic [2*CW-1:0] cur_pos,
  input logic [2*CW-1:0] cur_size,
  input logic [2*CW-1:0] cur_src,
  input logic [CW-1:0]   act_disp_w
);

  // R13: valid output trails valid input by one cycle
  p_valid_follow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_out_valid);

  p_valid_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !pix_out_valid);

  // R13: with the cursor off the background passes untouched
  p_pass_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !cur_on) |=> pix_out == $past(pix_in));

  // R9: geometry only moves after a frame boundary
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cur_pos) && $stable(cur_size) && $stable(cur_src)));

  // R4: a drawn cursor lies inside the display width
  p_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_on |-> ({1'b0, cur_pos[CW-1:0]} + {1'b0, cur_size[CW-1:0]}) <= {1'b0, act_disp_w});

  // R2: a drawn cursor never exceeds the long limit
  p_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_on |-> (cur_size[CW-1:0] <= CW'(MAX_LONG)) && (cur_size[2*CW-1:CW] <= CW'(MAX_LONG)));

  // R12: no cursor while the memories sleep
  p_sleep_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sleep |-> !cur_on);

  // R11: the fill sweep starts as sleep ends, cursor stays off
  p_fill_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_sleep) |-> !cur_on);

endmodule

bind cursor_overlay cursor_overlay_chk #(.CW(CW), .MAX_LONG(MAX_LONG)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ram_sleep(ram_sleep),
  .pix_valid(pix_valid), .pix_in(pix_in), .pix_out_valid(pix_out_valid),
  .pix_out(pix_out), .cur_on(cur_on), .cur_pos(cur_pos), .cur_size(cur_size),
  .cur_src(cur_src), .act_disp_w(act_dw)
);

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
  localparam int CLK_P     = 10;
  localparam int CW        = 16;
  localparam int MAX_LONG  = 8;
  localparam int MAX_SHORT = 4;
  localparam int SZW       = $clog2(MAX_LONG) + 1;
  localparam int TRA_W     = $clog2(MAX_LONG * MAX_SHORT) - 4;

  logic clk, rst_n;
  logic cfg_enable, cfg_interlace, frame_start, ram_sleep;
  logic signed [CW-1:0] cfg_pos_x, cfg_pos_y;
  logic [SZW-1:0] cfg_size_w, cfg_size_h;
  logic [CW-1:0]  cfg_disp_w, cfg_disp_h;
  logic img_load_start, img_wr_en, tr_wr_en, pix_valid;
  logic [31:0] img_wr_data, tr_wr_data;
  logic [TRA_W-1:0] tr_wr_addr;
  logic [CW-1:0] pix_x, pix_y;
  logic [23:0] pix_in, pix_out;
  logic pix_out_valid, cur_on;
  logic [2*CW-1:0] cur_pos, cur_size, cur_src;

  int checks = 0;
  int errors = 0;

  cursor_overlay #(.CW(CW), .MAX_LONG(MAX_LONG), .MAX_SHORT(MAX_SHORT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_pos_x(cfg_pos_x),
    .cfg_pos_y(cfg_pos_y), .cfg_size_w(cfg_size_w), .cfg_size_h(cfg_size_h),
    .cfg_disp_w(cfg_disp_w), .cfg_disp_h(cfg_disp_h), .cfg_interlace(cfg_interlace),
    .frame_start(frame_start), .ram_sleep(ram_sleep), .img_load_start(img_load_start),
    .img_wr_en(img_wr_en), .img_wr_data(img_wr_data), .tr_wr_en(tr_wr_en),
    .tr_wr_addr(tr_wr_addr), .tr_wr_data(tr_wr_data), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in), .pix_out_valid(pix_out_valid),
    .pix_out(pix_out), .cur_on(cur_on), .cur_pos(cur_pos), .cur_size(cur_size),
    .cur_src(cur_src)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  localparam logic [23:0] BG = 24'h123456;

  function automatic logic [31:0] img_word(input int i);
    logic [7:0] b = i[7:0];
    return {8'h80, b, 8'h40 + b, 8'hC0 + b};
  endfunction

  function automatic logic [23:0] img_out(input int i);
    logic [7:0] b = i[7:0];
    return {8'hC0 + b, 8'h40 + b, b};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame();
    frame_start = 1'b1;
    step(1);
    frame_start = 1'b0;
  endtask

  task automatic pix(input int x, input int y, input logic [23:0] exp, input string tag);
    pix_valid = 1'b1;
    pix_x = CW'(x);
    pix_y = CW'(y);
    pix_in = BG;
    step(1);
    pix_valid = 1'b0;
    chk(tag, {40'd0, pix_out}, {40'd0, exp});
  endtask

  task automatic load(input int w, input int h);
    cfg_size_w = SZW'(w);
    cfg_size_h = SZW'(h);
    img_load_start = 1'b1;
    step(1);
    img_load_start = 1'b0;
    for (int i = 0; i < w * h; i++) begin
      img_wr_en = 1'b1;
      img_wr_data = img_word(i);
      step(1);
    end
    img_wr_en = 1'b0;
  endtask

  task automatic trw(input int a, input logic [31:0] d);
    tr_wr_en = 1'b1;
    tr_wr_addr = TRA_W'(a);
    tr_wr_data = d;
    step(1);
    tr_wr_en = 1'b0;
  endtask

  task automatic place(input int x, input int y);
    cfg_pos_x = CW'(x);
    cfg_pos_y = CW'(y);
    frame();
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {63'd0, pix_out_valid}, 64'd0);
    chk("R1 reset pixel", {40'd0, pix_out}, 64'd0);
    chk("R1 reset cursor", {63'd0, cur_on}, 64'd0);
    chk("R1 reset geometry", {cur_pos, cur_size}, 64'd0);
  endtask

  task automatic t_pass();
    pix(3, 3, BG, "R13 pass with cursor off");
    chk("R13 valid follows", {63'd0, pix_out_valid}, 64'd1);
    pix_in = 24'hABCDEF;
    step(1);
    chk("R13 valid drops", {63'd0, pix_out_valid}, 64'd0);
    chk("R13 output held", {40'd0, pix_out}, {40'd0, BG});
  endtask

  task automatic t_default_clear();
    load(8, 4);
    cfg_enable = 1'b1;
    place(2, 3);
    chk("R11 cursor on after fill", {63'd0, cur_on}, 64'd1);
    pix(2, 3, BG, "R11 default code is clear");
    pix(9, 6, BG, "R11 default code second word");
  endtask

  task automatic t_basic();
    trw(0, 32'h0);
    trw(1, 32'h0);
    chk("R6 packed position", {32'd0, cur_pos}, {32'd0, 16'd3, 16'd2});
    chk("R6 packed size", {32'd0, cur_size}, {32'd0, 16'd4, 16'd8});
    chk("R6 packed source", {32'd0, cur_src}, 64'd0);
    pix(2, 3, img_out(0), "R7 first pixel bank0 swapped");
    pix(9, 6, img_out(31), "R7 last pixel bank1");
    pix(5, 4, img_out(11), "R7 row stride");
    pix(10, 3, BG, "R13 right of window");
    pix(5, 2, BG, "R13 above window");
  endtask

  task automatic t_neg();
    place(-3, -1);
    chk("R3 neg position", {32'd0, cur_pos}, 64'd0);
    chk("R3 neg size", {32'd0, cur_size}, {32'd0, 16'd3, 16'd5});
    chk("R3 neg source", {32'd0, cur_src}, {32'd0, 16'd1, 16'd3});
    pix(0, 0, img_out(11), "R3 corner pixel");
    pix(4, 2, img_out(31), "R3 far pixel");
    pix(5, 0, BG, "R3 past visible width");
    place(-8, 0);
    chk("R3 fully left off", {63'd0, cur_on}, 64'd0);
  endtask

  task automatic t_far();
    place(16, 10);
    chk("R4 clipped size", {32'd0, cur_size}, {32'd0, 16'd2, 16'd4});
    chk("R4 clipped position", {32'd0, cur_pos}, {32'd0, 16'd10, 16'd16});
    pix(19, 11, img_out(11), "R4 bottom right pixel");
    place(20, 0);
    chk("R4 zero width off", {63'd0, cur_on}, 64'd0);
    chk("R4 zero width value", {48'd0, cur_size[15:0]}, 64'd0);
  endtask

  task automatic t_il();
    cfg_interlace = 1'b1;
    place(2, 4);
    chk("R5 halved size", {32'd0, cur_size}, {32'd0, 16'd2, 16'd8});
    chk("R5 halved row", {32'd0, cur_pos}, {32'd0, 16'd2, 16'd2});
    pix(2, 3, img_out(16), "R5 field row steps two");
    cfg_interlace = 1'b0;
    place(2, 3);
  endtask

  task automatic t_frame();
    cfg_pos_x = 16'sd5;
    cfg_pos_y = 16'sd5;
    step(3);
    chk("R9 held before boundary", {32'd0, cur_pos}, {32'd0, 16'd3, 16'd2});
    frame();
    chk("R9 applied at boundary", {32'd0, cur_pos}, {32'd0, 16'd5, 16'd5});
    place(2, 3);
  endtask

  task automatic t_tr();
    trw(0, 32'h0000_0039);
    pix(2, 3, BG, "R10 code 01 clear");
    pix(3, 3, ~BG, "R10 code 10 invert");
    pix(4, 3, img_out(2), "R10 code 11 keyed");
    pix(5, 3, img_out(3), "R10 code 00 solid");
    trw(0, 32'h0);
  endtask

  task automatic t_size();
    cfg_size_w = 4'd4;
    cfg_size_h = 4'd8;
    frame();
    chk("R8 size change drops cursor", {63'd0, cur_on}, 64'd0);
    load(4, 8);
    chk("R8 reload restores cursor", {63'd0, cur_on}, 64'd1);
    load(8, 5);
    frame();
    chk("R2 both above short limit", {63'd0, cur_on}, 64'd0);
    load(9, 2);
    frame();
    chk("R2 width above long limit", {63'd0, cur_on}, 64'd0);
    load(8, 4);
    frame();
    chk("R2 legal size on", {63'd0, cur_on}, 64'd1);
  endtask

  task automatic t_sleep();
    ram_sleep = 1'b1;
    step(1);
    chk("R12 off while asleep", {63'd0, cur_on}, 64'd0);
    step(2);
    ram_sleep = 1'b0;
    tr_wr_en = 1'b1;
    tr_wr_addr = '0;
    tr_wr_data = 32'h0;
    step(1);
    tr_wr_en = 1'b0;
    step(4);
    chk("R12 image unloaded after sleep", {63'd0, cur_on}, 64'd0);
    load(8, 4);
    chk("R12 reload restores cursor", {63'd0, cur_on}, 64'd1);
    pix(3, 3, BG, "R11 write during fill dropped");
    pix(2, 4, BG, "R11 refilled code clear");
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_enable = 1'b0; cfg_interlace = 1'b0; frame_start = 1'b0; ram_sleep = 1'b0;
    cfg_pos_x = '0; cfg_pos_y = '0; cfg_size_w = '0; cfg_size_h = '0;
    cfg_disp_w = 16'd20; cfg_disp_h = 16'd12;
    img_load_start = 1'b0; img_wr_en = 1'b0; img_wr_data = '0;
    tr_wr_en = 1'b0; tr_wr_addr = '0; tr_wr_data = '0;
    pix_valid = 1'b0; pix_x = '0; pix_y = '0; pix_in = BG;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(4);
    t_pass();
    t_default_clear();
    t_basic();
    t_neg();
    t_far();
    t_il();
    t_frame();
    t_tr();
    t_size();
    t_sleep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule